// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block moves a low-power controller's system clock between a 32.768 kHz low-speed source and a high-speed source. It does not touch analog parts or clock multiplexers. It only drives the control bits that govern them, in a fixed interlocked order:

- the halver-mode control of the low-speed regulator;
- the high-speed regulator enable;
- the internal logic voltage select;
- the fast oscillator enable;
- the clock-select bit.

Between steps it inserts settling waits. The waits are counted in low-speed ticks, which arrive on a one-cycle strobe.

Requests arrive as one-cycle pulses:

- A switch-up request raises the voltage first, then the oscillator, then the clock select.
- A switch-down request lowers them in the reverse order. It can leave the low-speed regulator in halver mode as a final step.
- A halt request is acknowledged only while the block is idle on the slow clock. At any other time it is refused with an error pulse.

Top module: `clksw_seq`

## Requirements
- R1: After synchronous reset, every control output is 0: halver_on, hs_reg_on, vsel_hi, osc_en and clk_fast. busy, done, halt_ack and halt_err are also 0.
- R2: A switch-up accepted while on the slow clock changes the outputs one at a time, in this order:
  1. halver_on goes to 0 (only if it was 1).
  2. hs_reg_on goes to 1.
  3. vsel_hi goes to 1.
  4. osc_en goes to 1.
  5. clk_fast goes to 1.
- R3: Between the rise of vsel_hi and the rise of osc_en, at least VOLT_WAIT_TICKS slow_tick strobes occur. The default is 82, which is 2.5 ms of the slow clock.
- R4: Between the rise of osc_en and the rise of clk_fast, at least OSC_WAIT_TICKS slow_tick strobes occur. The default is 164, which is 5 ms.
- R5: A switch-down accepted while on the fast clock changes the outputs one at a time, in this order:
  1. clk_fast goes to 0.
  2. osc_en goes to 0.
  3. vsel_hi goes to 0.
  4. hs_reg_on goes to 0.
  5. halver_on takes the value of halver_req.
- R6: clk_fast is never 1 while halver_on is 1. halver_on is never 1 when vsel_hi rises. While idle on the slow clock, halver_on follows halver_req one cycle later. While on the fast clock, halver_req has no effect.
- R7: A halt_req pulse gives a halt_ack pulse in the next cycle only when the block is idle on the slow clock. At any other time, whether on the fast clock or while busy, it gives a halt_err pulse instead and no acknowledgement.
- R8: busy is 1 from the cycle after a request is accepted until the cycle in which done pulses. done is a single-cycle pulse at the end of each sequence. Requests that arrive while busy are ignored and change no output.
- R9: A switch-up while already on the fast clock, or a switch-down while already on the slow clock, pulses done in the next cycle without raising busy and without changing any control output.
- R10: When switch-up and switch-down are requested in the same cycle, switch-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per low-speed clock period |
| req_up | input | 1 | Request to move to the fast clock |
| req_down | input | 1 | Request to move to the slow clock |
| halver_req | input | 1 | Desired halver mode of the low-speed regulator while on the slow clock |
| halt_req | input | 1 | Request to halt the processor |
| halver_on | output | 1 | Low-speed regulator in halver mode |
| hs_reg_on | output | 1 | High-speed regulator enabled |
| vsel_hi | output | 1 | Internal logic voltage select, 1 = fast-clock level |
| osc_en | output | 1 | Fast oscillator enable |
| clk_fast | output | 1 | Clock select, 1 = fast source |
| busy | output | 1 | A switching sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence or no-op request |
| halt_ack | output | 1 | Halt request granted |
| halt_err | output | 1 | Halt request refused |

## Verification
The hardest state to reach is a request or halt arriving in the middle of a long settling wait. The bench reaches it by issuing a switch-up and then, well inside the first wait, pulsing a conflicting switch-down, a second switch-up and a halt. The scoreboard then flags any output change that was not pushed as expected, and any done pulse beyond the one expected.

The halver interlock needs a sequence that starts with halver mode active. The bench gets there by finishing a switch-down with halver_req held high, so the next switch-up must clear halver mode before anything else.

Tick gaps are measured by counting strobes between successive control changes. The strobe comes every fourth cycle, so both waits span several hundred cycles.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_HALV,
    ST_UP_HSREG,
    ST_UP_VSEL,
    ST_UP_WVOLT,
    ST_UP_OSC,
    ST_UP_WOSC,
    ST_UP_CLK,
    ST_DN_CLK,
    ST_DN_OSC,
    ST_DN_VSEL,
    ST_DN_HSREG,
    ST_DN_HALV
  } sw_state_t;

  typedef struct packed {
    logic halver;
    logic hs_on;
    logic vsel;
    logic osc;
    logic fast;
  } sw_ctl_t;

endpackage

// File: rtl/clksw_timer.sv
module clksw_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          tick,
  output logic          expired
);

  logic [TW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= len;
    end else if (tick && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expired = (count == '0);

  // R3
  load_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (load && len != '0) |=> !expired);

endmodule

// File: rtl/clksw_halt.sv
module clksw_halt (
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic busy,
  input  logic fast,
  output logic halt_ack,
  output logic halt_err
);

  logic allowed;
  assign allowed = !busy && !fast;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_ack <= 1'b0;
      halt_err <= 1'b0;
    end else begin
      halt_ack <= halt_req && allowed;
      halt_err <= halt_req && !allowed;
    end
  end

  // R7
  halt_ack_slow_chk: assert property (@(posedge clk) disable iff (rst)
    halt_ack |-> !fast);

  // R7
  halt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(halt_ack && halt_err));

endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
#(
  parameter int VOLT_WAIT = 82,
  parameter int OSC_WAIT  = 164,
  parameter int TW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_up,
  input  logic          req_down,
  input  logic          halver_req,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_len,
  output sw_ctl_t       ctl,
  output logic          busy,
  output logic          done
);

  sw_state_t st;

  assign tmr_load = (st == ST_UP_VSEL) || (st == ST_UP_OSC);
  assign tmr_len  = (st == ST_UP_OSC) ? TW'(OSC_WAIT) : TW'(VOLT_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      ctl  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_up) begin
            if (ctl.fast) begin
              done <= 1'b1;
            end else begin
              busy <= 1'b1;
              st   <= ST_UP_HALV;
            end
          end else if (req_down) begin
            if (!ctl.fast) begin
              done <= 1'b1;
            end else begin
              busy <= 1'b1;
              st   <= ST_DN_CLK;
            end
          end else if (!ctl.fast) begin
            ctl.halver <= halver_req;
          end
        end
        ST_UP_HALV: begin
          ctl.halver <= 1'b0;
          st         <= ST_UP_HSREG;
        end
        ST_UP_HSREG: begin
          ctl.hs_on <= 1'b1;
          st        <= ST_UP_VSEL;
        end
        ST_UP_VSEL: begin
          ctl.vsel <= 1'b1;
          st       <= ST_UP_WVOLT;
        end
        ST_UP_WVOLT: if (tmr_expired) st <= ST_UP_OSC;
        ST_UP_OSC: begin
          ctl.osc <= 1'b1;
          st      <= ST_UP_WOSC;
        end
        ST_UP_WOSC: if (tmr_expired) st <= ST_UP_CLK;
        ST_UP_CLK: begin
          ctl.fast <= 1'b1;
          busy     <= 1'b0;
          done     <= 1'b1;
          st       <= ST_IDLE;
        end
        ST_DN_CLK: begin
          ctl.fast <= 1'b0;
          st       <= ST_DN_OSC;
        end
        ST_DN_OSC: begin
          ctl.osc <= 1'b0;
          st      <= ST_DN_VSEL;
        end
        ST_DN_VSEL: begin
          ctl.vsel <= 1'b0;
          st       <= ST_DN_HSREG;
        end
        ST_DN_HSREG: begin
          ctl.hs_on <= 1'b0;
          st        <= ST_DN_HALV;
        end
        ST_DN_HALV: begin
          ctl.halver <= halver_req;
          busy       <= 1'b0;
          done       <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2 R6
  fast_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.fast |-> (!ctl.halver && ctl.osc && ctl.vsel && ctl.hs_on));

  // R2
  osc_needs_vsel_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.osc |-> ctl.vsel);

  // R3
  osc_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.osc) |-> $past(tmr_expired));

  // R4
  clk_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.fast) |-> $past(tmr_expired, 2));

  // R6
  vsel_rise_no_halver_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.vsel) |-> !ctl.halver);

  // R5
  osc_off_after_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl.osc) |-> !ctl.fast);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq #(
  parameter int VOLT_WAIT_TICKS = 82,
  parameter int OSC_WAIT_TICKS  = 164
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic req_up,
  input  logic req_down,
  input  logic halver_req,
  input  logic halt_req,
  output logic halver_on,
  output logic hs_reg_on,
  output logic vsel_hi,
  output logic osc_en,
  output logic clk_fast,
  output logic busy,
  output logic done,
  output logic halt_ack,
  output logic halt_err
);
  import clksw_pkg::*;

  localparam int MAXW = (VOLT_WAIT_TICKS > OSC_WAIT_TICKS) ? VOLT_WAIT_TICKS : OSC_WAIT_TICKS;
  localparam int TW   = $clog2(MAXW + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_len;
  logic          tmr_expired;
  sw_ctl_t       ctl;

  clksw_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len     (tmr_len),
    .tick    (slow_tick),
    .expired (tmr_expired)
  );

  clksw_fsm #(
    .VOLT_WAIT (VOLT_WAIT_TICKS),
    .OSC_WAIT  (OSC_WAIT_TICKS),
    .TW        (TW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_up      (req_up),
    .req_down    (req_down),
    .halver_req  (halver_req),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_len     (tmr_len),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done)
  );

  clksw_halt u_halt (
    .clk      (clk),
    .rst      (rst),
    .halt_req (halt_req),
    .busy     (busy),
    .fast     (ctl.fast),
    .halt_ack (halt_ack),
    .halt_err (halt_err)
  );

  assign halver_on = ctl.halver;
  assign hs_reg_on = ctl.hs_on;
  assign vsel_hi   = ctl.vsel;
  assign osc_en    = ctl.osc;
  assign clk_fast  = ctl.fast;

endmodule

// File: tb/clksw_seq_test.sv
module clksw_seq_test;

  localparam int VOLT = 82;
  localparam int OSC  = 164;

  logic clk = 0;
  logic rst = 1;
  logic slow_tick = 0;
  logic req_up = 0, req_down = 0, halver_req = 0, halt_req = 0;
  logic halver_on, hs_reg_on, vsel_hi, osc_en, clk_fast, busy, done, halt_ack, halt_err;

  always #5 clk = ~clk;

  clksw_seq #(.VOLT_WAIT_TICKS(VOLT), .OSC_WAIT_TICKS(OSC)) uut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .req_up(req_up), .req_down(req_down),
    .halver_req(halver_req), .halt_req(halt_req), .halver_on(halver_on),
    .hs_reg_on(hs_reg_on), .vsel_hi(vsel_hi), .osc_en(osc_en), .clk_fast(clk_fast),
    .busy(busy), .done(done), .halt_ack(halt_ack), .halt_err(halt_err)
  );

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q[$];
  int         min_q[$];
  logic [4:0] model = '0;
  int done_cnt = 0;
  logic finished = 0;

  wire [4:0] bundle = {halver_on, hs_reg_on, vsel_hi, osc_en, clk_fast};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_step(input int bitpos, input logic val, input int mint);
    logic [4:0] nxt;
    nxt = model;
    nxt[bitpos] = val;
    if (nxt != model) begin
      exp_q.push_back(nxt);
      min_q.push_back(mint);
    end
    model = nxt;
  endtask

  // monitor, scoreboard and tick source in one negedge process
  logic [4:0] prev = '0;
  int ticks = 0;
  int phase = 0;
  always @(negedge clk) begin
    if (slow_tick) ticks++;
    if (!rst) begin
      if (done) done_cnt++;
      if (bundle != prev) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6/R8 unexpected control change", bundle, prev);
        end else begin
          logic [4:0] e;
          int m;
          e = exp_q.pop_front();
          m = min_q.pop_front();
          chk(bundle == e, "R2/R5/R6 control order", bundle, e);
          if (m > 0) chk(ticks >= m, "R3/R4 settling ticks", ticks, m);
        end
        prev = bundle;
        ticks = 0;
      end
    end
    phase = (phase + 1) % 4;
    slow_tick = (phase == 0);
  end

  task automatic pulse_req(input bit up, input bit dn);
    req_up = up;
    req_down = dn;
    @(negedge clk);
    req_up = 0;
    req_down = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic switch_up();
    int d0;
    d0 = done_cnt;
    push_step(4, 1'b0, 0);
    push_step(3, 1'b1, 0);
    push_step(2, 1'b1, 0);
    push_step(1, 1'b1, VOLT);
    push_step(0, 1'b1, OSC);
    pulse_req(1, 0);
    chk(busy == 1, "R8 busy after switch-up accepted", busy, 1);
    wait_done();
    chk(exp_q.size() == 0, "R2 up sequence complete", exp_q.size(), 0);
    chk(done_cnt == d0 + 1, "R8 single done pulse", done_cnt - d0, 1);
    chk(busy == 0, "R8 busy cleared", busy, 0);
  endtask

  task automatic switch_down();
    int d0;
    d0 = done_cnt;
    push_step(0, 1'b0, 0);
    push_step(1, 1'b0, 0);
    push_step(2, 1'b0, 0);
    push_step(3, 1'b0, 0);
    push_step(4, halver_req, 0);
    pulse_req(0, 1);
    chk(busy == 1, "R8 busy after switch-down accepted", busy, 1);
    wait_done();
    chk(exp_q.size() == 0, "R5 down sequence complete", exp_q.size(), 0);
    chk(done_cnt == d0 + 1, "R8 single done pulse", done_cnt - d0, 1);
  endtask

  task automatic noop(input bit up);
    pulse_req(up, !up);
    chk(done == 1 && busy == 0, "R9 immediate done without busy", {done, busy}, 2'b10);
    repeat (3) @(negedge clk);
    chk(bundle == model, "R9 no control change", bundle, model);
  endtask

  task automatic halt(input bit expect_ack);
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    chk(halt_ack == expect_ack && halt_err == !expect_ack, "R7 halt response",
        {halt_ack, halt_err}, {expect_ack, !expect_ack});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({bundle, busy, done, halt_ack, halt_err} == '0, "R1 reset state",
        {bundle, busy, done, halt_ack, halt_err}, 0);

    halt(1);
    noop(0);

    // switch-up with requests and a halt injected mid-wait
    begin
      int d0;
      d0 = done_cnt;
      push_step(4, 1'b0, 0);
      push_step(3, 1'b1, 0);
      push_step(2, 1'b1, 0);
      push_step(1, 1'b1, VOLT);
      push_step(0, 1'b1, OSC);
      pulse_req(1, 0);
      chk(busy == 1, "R8 busy after accept", busy, 1);
      repeat (40) @(negedge clk);
      pulse_req(0, 1);
      pulse_req(1, 0);
      halt(0);
      wait_done();
      chk(exp_q.size() == 0, "R2 up sequence with ignored requests", exp_q.size(), 0);
      chk(done_cnt == d0 + 1, "R8 requests ignored while busy", done_cnt - d0, 1);
      chk(clk_fast == 1, "R4 fast clock selected", clk_fast, 1);
    end

    halt(0);
    noop(1);

    // halver_req has no effect on the fast clock
    halver_req = 1;
    repeat (5) @(negedge clk);
    chk(halver_on == 0, "R6 halver ignored on fast clock", halver_on, 0);

    switch_down();
    chk(halver_on == 1, "R5 halver entered on switch-down", halver_on, 1);

    // switch-up from halver mode must clear it first
    switch_up();
    halver_req = 0;
    repeat (3) @(negedge clk);
    switch_down();
    chk(halver_on == 0, "R5 halver stays off", halver_on, 0);

    // halver follows request in slow idle
    push_step(4, 1'b1, 0);
    halver_req = 1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && halver_on == 1, "R6 halver follows in slow idle", halver_on, 1);
    push_step(4, 1'b0, 0);
    halver_req = 0;
    repeat (3) @(negedge clk);
    chk(halver_on == 0, "R6 halver released in slow idle", halver_on, 0);

    // simultaneous requests: switch-up wins
    switch_up_both();
    switch_down();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic switch_up_both();
    push_step(4, 1'b0, 0);
    push_step(3, 1'b1, 0);
    push_step(2, 1'b1, 0);
    push_step(1, 1'b1, VOLT);
    push_step(0, 1'b1, OSC);
    pulse_req(1, 1);
    chk(busy == 1, "R10 combined request accepted", busy, 1);
    wait_done();
    chk(clk_fast == 1 && exp_q.size() == 0, "R10 switch-up wins", clk_fast, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule